// File: doc/BRIEF.md
# Gated Output Sequencer with Override

This block forms the last stage of a streaming output engine. It sits on the read side of a show-ahead output FIFO in the streaming clock domain. Each word it takes from the FIFO becomes the new output state, and that state is held until the next word is taken. A word is taken only while an upstream trigger reports the engine as triggered, the effective gate is open and nothing has halted the stream.

The gate is built from one of two sources: a dedicated gate pin, or any bit of the trigger bus that a mask selects. Gating can also be turned off, in which case the gate is always open. A closed gate only pauses the stream: the last word stays on the output, and the following words come out in order once the gate opens again.

Until the first word arrives, the output shows a programmable initial value. A software override value can replace the visible output at any time, and the raw streamed word stays readable on its own port. The block reports the following:
- a valid qualifier;
- a strobe for every word taken;
- a sticky done flag, set when the word carrying the end-of-stream marker is consumed;
- a sticky underrun error.

An optional policy halts the stream once an underrun has occurred.

Top module: `gated_out_seq`

## Requirements
- R1: `fifo_rd` is high in a cycle only if all of the following hold: `triggered` is 1, the effective gate is open, `stop` is 0, `done` is 0, the stop-on-error halt is not active, and `fifo_empty` is 0. When all of these hold, `fifo_rd` is high and one word is consumed at that clock edge.
- R2: The effective gate follows these rules. With `gate_en`=0 it is always open. With `gate_en`=1 and `gate_src`=0 it equals `gate_in`. With `gate_en`=1 and `gate_src`=1 it is open when any bit of `trig_bus & gate_mask` is 1, so an all-zero mask keeps it closed.
- R3: While the gate is closed, `q_raw` holds the last consumed word. When the gate reopens, the next FIFO words appear in order.
- R4: Before the first word is consumed after reset, `q_valid` is 0 and `q_raw` equals `init_val`. After that, stalls never return the output to `init_val`.
- R5: With `ovr_sel`=1, `q_out` equals `ovr_val`. With `ovr_sel`=0, `q_out` equals `q_raw`. `q_raw` is never affected by the override.
- R6: `stop`=1 prevents reads. After an underrun, reads continue while `stop_on_err`=0 and are blocked while `stop_on_err`=1.
- R7: In the cycle after each consume, `q_strobe` is 1, `q_raw` equals the consumed word and `q_valid` is 1. `q_strobe` is 0 after any cycle without a consume, and `q_valid` stays 1 until reset.
- R8: Consuming a word with `fifo_last`=1 sets `done` in the next cycle. `done` stays set until reset, and no further reads occur after it is set.
- R9: `buf_err` is set in the cycle after one in which the stream would advance but `fifo_empty` is 1. It stays set until reset and is never set after `done`.
- R10: During and right after reset, `fifo_rd`, `q_valid`, `q_strobe`, `done` and `buf_err` are 0, and `q_out` equals `init_val` when `ovr_sel`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Streaming-domain clock |
| rst_n | input | 1 | Active-low synchronous reset |
| triggered | input | 1 | Trigger logic reports the engine as started |
| stop | input | 1 | Halts advancement while high |
| stop_on_err | input | 1 | Halts advancement once an underrun is flagged |
| gate_en | input | 1 | Enables gating; 0 keeps the gate open |
| gate_src | input | 1 | Gate source: 0 gate pin, 1 masked trigger bus |
| gate_in | input | 1 | Dedicated gate pin |
| trig_bus | input | TW | Trigger bus |
| gate_mask | input | TW | Trigger bus bits that can open the gate |
| init_val | input | DW | Output value shown before the first word |
| ovr_sel | input | 1 | Selects the override value for `q_out` |
| ovr_val | input | DW | Override output value |
| fifo_empty | input | 1 | Output FIFO has no word |
| fifo_data | input | DW | Head word of the FIFO (show-ahead) |
| fifo_last | input | 1 | Head word carries the end-of-stream marker |
| fifo_rd | output | 1 | Pop request for the head word |
| q_raw | output | DW | Streamed output before the override mux |
| q_out | output | DW | Final output word |
| q_valid | output | 1 | A streamed word is being held |
| q_strobe | output | 1 | Pulse after each consumed word |
| done | output | 1 | Sticky: end-of-stream word consumed |
| buf_err | output | 1 | Sticky: underrun seen |

## Verification
A wrong gate decode or halt term shows up at once on `fifo_rd`, in the same cycle the inputs change. The bench therefore samples that pin combinationally over a table of gate configurations. A corrupted hold register or a wrongly qualified pop shows up one edge later: `q_raw` skips a word, repeats a word or falls back to the initial value, and `q_strobe` fires or fails to fire on that same cycle. Wrong sticky-flag handling can hide until the FIFO drains or the marked word is reached. Directed tests therefore run every stream to its end and check `done`, `buf_err` and the absence of reads one cycle later.

// File: rtl/gated_out_seq.sv
`timescale 1ns/1ps
module gated_out_seq #(
  parameter int DW = 16,
  parameter int TW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          triggered,
  input  logic          stop,
  input  logic          stop_on_err,
  input  logic          gate_en,
  input  logic          gate_src,
  input  logic          gate_in,
  input  logic [TW-1:0] trig_bus,
  input  logic [TW-1:0] gate_mask,
  input  logic [DW-1:0] init_val,
  input  logic          ovr_sel,
  input  logic [DW-1:0] ovr_val,
  input  logic          fifo_empty,
  input  logic [DW-1:0] fifo_data,
  input  logic          fifo_last,
  output logic          fifo_rd,
  output logic [DW-1:0] q_raw,
  output logic [DW-1:0] q_out,
  output logic          q_valid,
  output logic          q_strobe,
  output logic          done,
  output logic          buf_err
);

  logic          gate_open;
  logic          halted;
  logic          advance;
  logic [DW-1:0] word_q;

  assign gate_open = !gate_en || (gate_src ? |(trig_bus & gate_mask) : gate_in);
  assign halted    = stop || done || (stop_on_err && buf_err);
  assign advance   = triggered && gate_open && !halted;
  assign fifo_rd   = advance && !fifo_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q   <= '0;
      q_valid  <= 1'b0;
      q_strobe <= 1'b0;
      done     <= 1'b0;
      buf_err  <= 1'b0;
    end else begin
      q_strobe <= fifo_rd;
      if (fifo_rd) begin
        word_q  <= fifo_data;
        q_valid <= 1'b1;
        if (fifo_last) done <= 1'b1;
      end
      if (advance && fifo_empty) buf_err <= 1'b1;
    end
  end

  assign q_raw = q_valid ? word_q : init_val;
  assign q_out = ovr_sel ? ovr_val : q_raw;

  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |-> !fifo_empty && triggered && !stop);                        // R1
  AST_WORD_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_rd |=> q_strobe && q_valid && (q_raw == $past(fifo_data)));       // R7
  AST_HOLD_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (q_valid && !fifo_rd) |=> $stable(q_raw) && !q_strobe);                // R3
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);                                                        // R8
  AST_NO_POP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fifo_rd);                                                    // R8
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    buf_err |=> buf_err);                                                  // R9
  AST_ERR_HALT: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_err && stop_on_err) |-> !fifo_rd);                                // R6

endmodule

// File: tb/gated_out_seq_tb.sv
`timescale 1ns/1ps
module gated_out_seq_tb;
  localparam int DW = 16;
  localparam int TW = 8;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, triggered, stop, stop_on_err, gate_en, gate_src, gate_in, ovr_sel;
  logic [TW-1:0] trig_bus, gate_mask;
  logic [DW-1:0] init_val, ovr_val;
  logic fifo_empty, fifo_last, fifo_rd, q_valid, q_strobe, done, buf_err;
  logic [DW-1:0] fifo_data, q_raw, q_out;

  int rd_ptr;
  int fill_cnt;
  int last_idx;
  logic fifo_clr;
  int compared = 0;
  int mismatched = 0;

  always @(posedge clk) begin
    if (fifo_clr) rd_ptr <= 0;
    else if (fifo_rd) rd_ptr <= rd_ptr + 1;
  end
  assign fifo_empty = (rd_ptr >= fill_cnt);
  assign fifo_data  = 16'hA000 + rd_ptr[15:0];
  assign fifo_last  = (rd_ptr == last_idx);

  gated_out_seq #(.DW(DW), .TW(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .triggered(triggered), .stop(stop),
    .stop_on_err(stop_on_err), .gate_en(gate_en), .gate_src(gate_src),
    .gate_in(gate_in), .trig_bus(trig_bus), .gate_mask(gate_mask),
    .init_val(init_val), .ovr_sel(ovr_sel), .ovr_val(ovr_val),
    .fifo_empty(fifo_empty), .fifo_data(fifo_data), .fifo_last(fifo_last),
    .fifo_rd(fifo_rd), .q_raw(q_raw), .q_out(q_out), .q_valid(q_valid),
    .q_strobe(q_strobe), .done(done), .buf_err(buf_err));

  // {gate_en, gate_src, gate_in, expect_open, mask[7:0], bus[7:0]}
  localparam logic [19:0] GATE_VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00},
    {1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hFF},
    {1'b1, 1'b0, 1'b1, 1'b1, 8'h00, 8'h00},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'hFF},
    {1'b1, 1'b1, 1'b0, 1'b0, 8'h0F, 8'hF0},
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h0F, 8'h08},
    {1'b1, 1'b1, 1'b0, 1'b1, 8'h81, 8'h80},
    {1'b1, 1'b1, 1'b1, 1'b0, 8'h81, 8'h7E}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input int cnt, input int last);
    @(negedge clk);
    rst_n = 1'b0; fifo_clr = 1'b1;
    triggered = 0; stop = 0; stop_on_err = 0; gate_en = 0; gate_src = 0;
    gate_in = 0; trig_bus = '0; gate_mask = '0; ovr_sel = 0; ovr_val = 16'h1234;
    fill_cnt = cnt; last_idx = last;
    step(); step();
    rst_n = 1'b1; fifo_clr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    rst_n = 1'b0; fifo_clr = 1'b1; init_val = 16'h5A5A;
    do_reset(4, -1);

    // R10 / R4: reset state
    check("R10 fifo_rd", fifo_rd, 0);
    check("R10 q_valid", q_valid, 0);
    check("R10 strobe", q_strobe, 0);
    check("R10 done", done, 0);
    check("R10 buf_err", buf_err, 0);
    check("R4 q_out init", q_out, 16'h5A5A);
    step();
    check("R1 no read untriggered", fifo_rd, 0);
    check("R4 q_raw init", q_raw, 16'h5A5A);

    // R2: gate source table, sampled on fifo_rd
    do_reset(1000, -1);
    triggered = 1;
    for (int i = 0; i < 8; i++) begin
      gate_en = GATE_VEC[i][19]; gate_src = GATE_VEC[i][18];
      gate_in = GATE_VEC[i][17]; gate_mask = GATE_VEC[i][15:8];
      trig_bus = GATE_VEC[i][7:0];
      #1;
      check("R2 gate vector", fifo_rd, GATE_VEC[i][16]);
      step();
    end

    // R1, R3, R5, R7, R9, R6 (continue without stop_on_err)
    do_reset(4, -1);
    triggered = 1; #1;
    check("R1 read enabled", fifo_rd, 1);
    step();
    check("R7 strobe", q_strobe, 1);
    check("R7 word", q_raw, 16'hA000);
    check("R7 valid", q_valid, 1);
    gate_en = 1; gate_src = 0; gate_in = 0; #1;
    check("R2 gate pin closed", fifo_rd, 0);
    step();
    check("R3 hold word", q_raw, 16'hA000);
    check("R7 strobe single", q_strobe, 0);
    step();
    check("R4 no return to init", q_raw, 16'hA000);
    check("R7 valid held", q_valid, 1);
    gate_in = 1;
    step();
    check("R3 resume in order", q_raw, 16'hA001);
    step();
    check("R3 next", q_raw, 16'hA002);
    step();
    check("R3 last word", q_raw, 16'hA003);
    check("R9 no early err", buf_err, 0);
    step();
    check("R9 underrun", buf_err, 1);
    check("R9 strobe none", q_strobe, 0);
    check("R9 hold", q_raw, 16'hA003);
    ovr_sel = 1; #1;
    check("R5 override out", q_out, 16'h1234);
    check("R5 raw unaffected", q_raw, 16'hA003);
    ovr_sel = 0; #1;
    check("R5 override off", q_out, 16'hA003);
    fill_cnt = 6;
    step();
    check("R6 continue after err", q_raw, 16'hA004);
    check("R9 err sticky", buf_err, 1);

    // R6: stop and stop-on-error
    do_reset(2, -1);
    triggered = 1; stop = 1; #1;
    check("R6 stop blocks", fifo_rd, 0);
    step();
    check("R6 stop no word", q_valid, 0);
    stop = 0;
    step();
    check("R6 after stop", q_raw, 16'hA000);
    step();
    check("R6 second", q_raw, 16'hA001);
    step();
    check("R9 drained", buf_err, 1);
    stop_on_err = 1; fill_cnt = 5; #1;
    check("R6 err halts", fifo_rd, 0);
    step();
    check("R6 held on halt", q_raw, 16'hA001);

    // R8: end-of-stream
    do_reset(10, 2);
    triggered = 1;
    step(); step();
    check("R8 not yet done", done, 0);
    step();
    check("R8 done", done, 1);
    check("R8 last word", q_raw, 16'hA002);
    #1;
    check("R8 no read after done", fifo_rd, 0);
    step();
    check("R8 sticky", done, 1);
    check("R9 no err after done", buf_err, 0);
    check("R8 word held", q_raw, 16'hA002);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule